// File: doc/BRIEF.md
# Accumulator-Based Digital Phase-Locked Loop

This block recovers a clock from a single-bit reference by steering a wrapping phase accumulator. A fast local tick clock drives the block. On every tick a per-tick step is added to a 16-bit accumulator. With no correction the step is one sixteenth of the accumulator range, so the accumulator wraps once every 16 ticks. The top bit of the accumulator is the recovered clock. A strobe marks the tick on which the accumulator wrapped.

The reference may drop edges, as data transitions do. Each rising edge that arrives, once synchronized, latches the accumulator value as a signed phase error. Zero means the two are aligned. A positive value means the local phase is late, and a negative value means it is early. The error is divided by 256 and taken off the step on every tick. An optional integral path sums the captured errors and takes a scaled share of that sum off the step as well, which removes the steady error caused by a frequency offset. The captured error is cleared when no new edge has come for 15 ticks, so a single measurement cannot steer the loop for long. The step is limited to the range of the accumulator.

Top module: `dpll_phase_acc`

## Requirements
- R1: While `rst_n` is low at a clock edge, that edge clears the accumulator, the error register, the stale counter, the integrator and the synchronizer. While reset is held, `rclk_o`, `wrap_o` and `err_o` are all 0.
- R2: With zero error and a zero integrator, the accumulator advances by 0x1000 per tick from 0. `rclk_o` is accumulator bit 15, so it is low after ticks 1 to 7 and high after ticks 8 to 15.
- R3: `wrap_o` is 1 for exactly the tick whose update carried the accumulator past 0xFFFF. After reset the first such tick is tick 16, and `wrap_o` is 0 again on the next tick.
- R4: Suppose `ref_i` is first sampled high at clock edge n. At edge n+2, `err_o` takes the accumulator value that was held between edges n+1 and n+2. Falling edges and steady levels of `ref_i` capture nothing.
- R5: The per-tick step is 0x1000 − (err >>> 8) − (integrator >>> 4). Here err is `err_o` read as 16-bit two's complement and the shifts are arithmetic.
- R6: The step is clamped to the range 0 to 0xFFFF. When the step is clamped to 0, the accumulator holds still: `rclk_o` does not move and `wrap_o` stays 0.
- R7: If no capture occurs on the 15 ticks that follow a capture, the 15th of those ticks clears `err_o` to 0. So a captured value is visible for exactly 15 samples.
- R8: Each capture adds the captured value, sign-extended, to a 24-bit integrator. The integrator keeps its value through the clearing of stale errors and is reset only by `rst_n`.
- R9: A capture and a stale clear can fall on the same tick. In that case the capture wins: `err_o` shows the new value and the 15-tick window starts again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Local tick clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ref_i | input | 1 | Asynchronous reference; rising edges measure phase |
| rclk_o | output | 1 | Recovered clock, accumulator MSB |
| wrap_o | output | 1 | One-tick strobe on accumulator overflow |
| err_o | output | 16 | Latched phase error, two's complement |

## Verification
A fresh capture and the 15-tick stale clear can land on the same tick. The bench provokes this with two reference rises exactly 15 ticks apart, so the second capture falls on the tick where the first value would expire. The check passes only if `err_o` shows the new, non-zero accumulator value, equal to the value predicted by a behavioural model that runs in parallel. If `err_o` reads zero, the clear has beaten the capture. Captures that fall near an accumulator wrap, and a step driven into its lower clamp, are judged against the same model.

// File: rtl/dpll_pkg.sv
// Package: default sizing for the accumulator phase-locked loop.
// Assumes an accumulator of at least 8 bits and a power-of-two nominal step.
package dpll_pkg;
    localparam int DPLL_ACC_W     = 16;
    localparam int DPLL_NOM_INC   = 4096;
    localparam int DPLL_P_SHIFT   = 8;
    localparam int DPLL_STALE     = 15;
    localparam int DPLL_I_SHIFT   = 4;
    localparam int DPLL_SYNC      = 2;
endpackage

// File: rtl/dpll_ref_edge.sv
// Reference front end: a synchronizer chain followed by a rising-edge detector.
// Produces a one-tick capture strobe. Assumes SYNC_STAGES >= 2.
module dpll_ref_edge #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_i,
    output logic cap_o
);
    logic [SYNC_STAGES-1:0] chain_q;
    logic                   last_q;

    // Shift the reference through the chain and remember the previous synchronized level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= '0;
            last_q  <= 1'b0;
        end else begin
            chain_q <= {chain_q[SYNC_STAGES-2:0], ref_i};
            last_q  <= chain_q[SYNC_STAGES-1];
        end
    end

    assign cap_o = chain_q[SYNC_STAGES-1] & ~last_q;
endmodule

// File: rtl/dpll_err_hold.sv
// Phase-error register with expiry. It latches the accumulator on a capture strobe
// and clears the value once STALE_TICKS ticks pass with no further capture.
// When a capture and the expiry fall on the same tick, the capture wins.
module dpll_err_hold #(
    parameter int ACC_W       = 16,
    parameter int STALE_TICKS = 15
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cap_i,
    input  logic [ACC_W-1:0] acc_i,
    output logic [ACC_W-1:0] err_o
);
    localparam int CW = $clog2(STALE_TICKS + 1);
    localparam logic [CW-1:0] LAST = CW'(STALE_TICKS - 1);
    localparam logic [CW-1:0] IDLE = CW'(STALE_TICKS);

    logic [CW-1:0] age_q;

    // Latch on capture; otherwise age the value and drop it when it expires.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_o <= '0;
            age_q <= '0;
        end else if (cap_i) begin
            err_o <= acc_i;
            age_q <= '0;
        end else if (age_q != IDLE) begin
            age_q <= age_q + 1'b1;
            if (age_q == LAST) begin
                err_o <= '0;
            end
        end
    end
endmodule

// File: rtl/dpll_loop_filter.sv
// Loop filter: forms the per-tick step from the nominal step, the proportional term
// (error >>> P_SHIFT) and an optional integral term (sum >>> I_SHIFT).
// The step is clamped to [0, 2^ACC_W-1]. Assumes INT_W >= ACC_W.
module dpll_loop_filter #(
    parameter int ACC_W   = 16,
    parameter int NOM_INC = 4096,
    parameter int P_SHIFT = 8,
    parameter int INT_EN  = 1,
    parameter int I_SHIFT = 4,
    parameter int INT_W   = 24
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cap_i,
    input  logic [ACC_W-1:0]        acc_i,
    input  logic [ACC_W-1:0]        err_i,
    output logic [ACC_W-1:0]        inc_o,
    output logic signed [INT_W-1:0] integ_o
);
    localparam int SW = INT_W + 2;
    localparam logic signed [SW-1:0] NOM_S = SW'(NOM_INC);
    localparam logic signed [SW-1:0] MAX_S = {{(SW-ACC_W){1'b0}}, {ACC_W{1'b1}}};

    logic signed [SW-1:0] p_ext;
    logic signed [SW-1:0] i_ext;
    logic signed [SW-1:0] raw;

    generate
        if (INT_EN != 0) begin : g_int
            // Sum every captured phase error as a signed value.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    integ_o <= '0;
                end else if (cap_i) begin
                    integ_o <= integ_o + INT_W'($signed(acc_i));
                end
            end
        end else begin : g_no_int
            assign integ_o = '0;
        end
    endgenerate

    // Subtract both correction terms from the nominal step and clamp the result.
    always_comb begin
        p_ext = SW'($signed(err_i) >>> P_SHIFT);
        i_ext = SW'(integ_o >>> I_SHIFT);
        raw   = NOM_S - p_ext - i_ext;
        if (raw < 0) begin
            inc_o = '0;
        end else if (raw > MAX_S) begin
            inc_o = '1;
        end else begin
            inc_o = raw[ACC_W-1:0];
        end
    end
endmodule

// File: rtl/dpll_nco.sv
// Phase accumulator: adds the step on every tick. The carry out is registered,
// so the wrap strobe lines up with the tick that holds the wrapped value.
module dpll_nco #(
    parameter int ACC_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [ACC_W-1:0] inc_i,
    output logic [ACC_W-1:0] acc_o,
    output logic             wrap_o
);
    logic [ACC_W:0] sum;

    assign sum = {1'b0, acc_o} + {1'b0, inc_i};

    // Advance the phase and record the overflow.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_o  <= '0;
            wrap_o <= 1'b0;
        end else begin
            acc_o  <= sum[ACC_W-1:0];
            wrap_o <= sum[ACC_W];
        end
    end
endmodule

// File: rtl/dpll_phase_acc.sv
// Top of the accumulator phase-locked loop. Assumes ref_i is asynchronous to clk,
// that clk is much faster than the reference, and that reset is synchronous and active-low.
module dpll_phase_acc
    import dpll_pkg::*;
#(
    parameter int ACC_W       = DPLL_ACC_W,
    parameter int NOM_INC     = DPLL_NOM_INC,
    parameter int P_SHIFT     = DPLL_P_SHIFT,
    parameter int STALE_TICKS = DPLL_STALE,
    parameter int INT_EN      = 1,
    parameter int I_SHIFT     = DPLL_I_SHIFT,
    parameter int INT_W       = ACC_W + 8,
    parameter int SYNC_STAGES = DPLL_SYNC
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ref_i,
    output logic             rclk_o,
    output logic             wrap_o,
    output logic [ACC_W-1:0] err_o
);
    logic                    cap_stb;
    logic [ACC_W-1:0]        acc_q;
    logic [ACC_W-1:0]        err_q;
    logic [ACC_W-1:0]        inc_w;
    logic signed [INT_W-1:0] integ_q;

    dpll_ref_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
        .clk(clk), .rst_n(rst_n), .ref_i(ref_i), .cap_o(cap_stb)
    );

    dpll_err_hold #(.ACC_W(ACC_W), .STALE_TICKS(STALE_TICKS)) u_err (
        .clk(clk), .rst_n(rst_n), .cap_i(cap_stb), .acc_i(acc_q), .err_o(err_q)
    );

    dpll_loop_filter #(
        .ACC_W(ACC_W), .NOM_INC(NOM_INC), .P_SHIFT(P_SHIFT),
        .INT_EN(INT_EN), .I_SHIFT(I_SHIFT), .INT_W(INT_W)
    ) u_filt (
        .clk(clk), .rst_n(rst_n), .cap_i(cap_stb), .acc_i(acc_q), .err_i(err_q),
        .inc_o(inc_w), .integ_o(integ_q)
    );

    dpll_nco #(.ACC_W(ACC_W)) u_nco (
        .clk(clk), .rst_n(rst_n), .inc_i(inc_w), .acc_o(acc_q), .wrap_o(wrap_o)
    );

    assign rclk_o = acc_q[ACC_W-1];
    assign err_o  = err_q;
endmodule

// File: rtl/dpll_phase_acc_chk.sv
// Checker for the accumulator phase-locked loop, bound to every instance of the top.
// Keeps its own count of ticks since the last capture to judge the expiry window.
module dpll_phase_acc_chk #(
    parameter int ACC_W       = 16,
    parameter int NOM_INC     = 4096,
    parameter int STALE_TICKS = 15,
    parameter int INT_W       = 24
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    cap,
    input logic [ACC_W-1:0]        acc,
    input logic [ACC_W-1:0]        inc,
    input logic [ACC_W-1:0]        err,
    input logic signed [INT_W-1:0] integ,
    input logic                    wrap
);
    localparam int SC = $clog2(STALE_TICKS + 1) + 1;

    logic          seen_q = 1'b0;
    logic [SC-1:0] since_q;

    // Mark that at least one clock edge has gone by.
    always_ff @(posedge clk) seen_q <= 1'b1;

    // Count ticks since the last capture, saturating at the expiry length.
    always_ff @(posedge clk) begin
        if (!rst_n)                         since_q <= SC'(STALE_TICKS);
        else if (cap)                       since_q <= '0;
        else if (since_q < SC'(STALE_TICKS)) since_q <= since_q + 1'b1;
    end

    p_reset_clear_r1: assert property (@(posedge clk)
        (seen_q && !$past(rst_n)) |-> (acc == '0 && err == '0 && integ == '0 && !wrap));

    p_nominal_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (err == '0 && integ == '0) |=> (acc == ACC_W'($past(acc) + ACC_W'(NOM_INC))));

    p_wrap_small_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |-> (acc < $past(inc)));

    p_capture_value_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cap |=> (err == $past(acc)));

    p_capture_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cap |=> !cap);

    p_zero_step_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (inc == '0) |=> $stable(acc));

    p_stale_cleared_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (since_q >= SC'(STALE_TICKS)) |-> (err == '0));

    p_integ_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !cap |=> $stable(integ));
endmodule

bind dpll_phase_acc dpll_phase_acc_chk #(
    .ACC_W(ACC_W), .NOM_INC(NOM_INC), .STALE_TICKS(STALE_TICKS), .INT_W(INT_W)
) chk_i (
    .clk(clk), .rst_n(rst_n), .cap(cap_stb), .acc(acc_q), .inc(inc_w),
    .err(err_q), .integ(integ_q), .wrap(wrap_o)
);

// File: tb/dpll_phase_acc_tb_top.sv
// Bench: a behavioural model built from the requirements runs beside the design and
// is compared at every falling edge. A table of reference patterns is walked first,
// then directed tests cover reset, free run, expiry, the capture/expiry collision
// and the step clamp.
module dpll_phase_acc_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ref_i = 1'b0;
    logic        rclk_o;
    logic        wrap_o;
    logic [15:0] err_o;

    int n_vec = 0;
    int n_bad = 0;
    int cyc = 0;
    bit cmp_en = 1'b0;

    // Model state
    int          m_acc = 0;
    logic [15:0] m_err = '0;
    longint      m_integ = 0;
    int          m_cnt = 0;
    bit          m_wrap = 1'b0;
    bit          m_s1 = 1'b0, m_s2 = 1'b0, m_s3 = 1'b0;

    dpll_phase_acc dut_i (
        .clk(clk), .rst_n(rst_n), .ref_i(ref_i),
        .rclk_o(rclk_o), .wrap_o(wrap_o), .err_o(err_o)
    );

    always #10 clk = ~clk;

    // Step from R5 with the clamp from R6.
    function automatic int model_inc(logic [15:0] e, longint ig);
        longint p, i, raw;
        p   = longint'(signed'(e)) >>> 8;
        i   = ig >>> 4;
        raw = 4096 - p - i;
        if (raw < 0) return 0;
        if (raw > 65535) return 65535;
        return int'(raw);
    endfunction

    task automatic summary_and_end();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // Behavioural model of R1-R9, advanced on each rising edge.
    always @(posedge clk) begin
        bit edge_v;
        int inc_v, nxt;
        if (!rst_n) begin
            m_acc = 0; m_err = '0; m_integ = 0; m_cnt = 0; m_wrap = 1'b0;
            m_s1 = 1'b0; m_s2 = 1'b0; m_s3 = 1'b0;
        end else begin
            edge_v = m_s2 && !m_s3;
            inc_v  = model_inc(m_err, m_integ);
            nxt    = m_acc + inc_v;
            if (edge_v) begin
                m_integ = m_integ + longint'(signed'(m_acc[15:0]));
                m_err   = m_acc[15:0];
                m_cnt   = 0;
            end else if (m_cnt < 15) begin
                if (m_cnt == 14) m_err = '0;
                m_cnt++;
            end
            m_wrap = (nxt > 65535);
            m_acc  = nxt & 32'hFFFF;
            m_s3 = m_s2; m_s2 = m_s1; m_s1 = ref_i;
        end
    end

    // Compare the design with the model away from the active edge.
    always @(negedge clk) begin
        if (rst_n && cmp_en) begin
            n_vec++;
            if (rclk_o !== m_acc[15] || wrap_o !== m_wrap || err_o !== m_err) begin
                n_bad++;
                if (rclk_o !== m_acc[15])
                    $display("FAIL R2 R5 R8 rclk_o actual=%0b expected=%0b", rclk_o, m_acc[15]);
                if (wrap_o !== m_wrap)
                    $display("FAIL R3 wrap_o actual=%0b expected=%0b", wrap_o, m_wrap);
                if (err_o !== m_err)
                    $display("FAIL R4 R7 err_o actual=0x%0h expected=0x%0h", err_o, m_err);
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still prints the summary.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 190000) begin
            n_bad++;
            $display("FAIL watchdog actual=%0d expected<190000", cyc);
            summary_and_end();
        end
    end

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk(rclk_o == 1'b0 && wrap_o == 1'b0 && err_o == 16'h0, "R1 reset outputs",
            {rclk_o, wrap_o, err_o}, 0);
        rst_n = 1'b1;
    endtask

    task automatic wait_wrap();
        for (int k = 0; k < 3000; k++) begin
            @(negedge clk);
            if (wrap_o) break;
        end
    endtask

    // Reference patterns: {ticks low, ticks high}. Gaps of 15 hit R9, long gaps hit R7,
    // short pulses and repeated falls exercise R4, and every capture feeds R8.
    localparam int VEC_N = 12;
    localparam int VEC_T [VEC_N][2] = '{
        '{20, 4}, '{8, 7}, '{8, 7}, '{9, 7}, '{3, 1}, '{1, 1},
        '{30, 2}, '{10, 6}, '{17, 5}, '{5, 12}, '{40, 3}, '{6, 9}
    };

    initial begin
        int first_nz, run;
        logic [15:0] v;
        logic r0;
        bit stable;

        cmp_en = 1'b0;
        do_reset();
        cmp_en = 1'b1;

        // R2 / R3: free run from reset.
        for (int t = 1; t <= 17; t++) begin
            @(negedge clk);
            if (t == 7)  chk(rclk_o == 1'b0, "R2 rclk after 7 ticks", rclk_o, 0);
            if (t == 8)  chk(rclk_o == 1'b1, "R2 rclk after 8 ticks", rclk_o, 1);
            if (t == 15) chk(wrap_o == 1'b0, "R3 no wrap at tick 15", wrap_o, 0);
            if (t == 16) chk(wrap_o == 1'b1, "R3 wrap at tick 16", wrap_o, 1);
            if (t == 17) chk(wrap_o == 1'b0, "R3 wrap lasts one tick", wrap_o, 0);
        end

        // Table walk: R4, R5, R7, R8, R9 through the model compare.
        for (int i = 0; i < VEC_N; i++) begin
            ref_i = 1'b0;
            repeat (VEC_T[i][0]) @(negedge clk);
            ref_i = 1'b1;
            repeat (VEC_T[i][1]) @(negedge clk);
        end
        ref_i = 1'b0;
        repeat (20) @(negedge clk);

        // R7: a lone capture stays visible for 15 samples.
        cmp_en = 1'b0;
        do_reset();
        cmp_en = 1'b1;
        repeat (20) @(negedge clk);
        wait_wrap();
        ref_i = 1'b1;
        repeat (3) @(negedge clk);
        v = err_o;
        chk(v != 16'h0 && v == m_err, "R4 capture value", v, m_err);
        ref_i = 1'b0;
        run = 1;
        for (int k = 0; k < 30; k++) begin
            @(negedge clk);
            if (err_o == v) run++;
            else break;
        end
        chk(run == 15, "R7 samples before clear", run, 15);
        chk(err_o == 16'h0, "R7 cleared value", err_o, 0);

        // R9: second rise 15 ticks after the first lands on the expiry tick.
        repeat (20) @(negedge clk);
        wait_wrap();
        ref_i = 1'b1;
        repeat (4) @(negedge clk);
        ref_i = 1'b0;
        repeat (11) @(negedge clk);
        ref_i = 1'b1;
        repeat (3) @(negedge clk);
        chk(err_o != 16'h0 && err_o == m_err, "R9 capture beats expiry", err_o, m_err);
        ref_i = 1'b0;
        repeat (20) @(negedge clk);

        // R6 / R8: drive the integrator until the step clamps at zero.
        cmp_en = 1'b0;
        do_reset();
        cmp_en = 1'b1;
        first_nz = 0;
        while (!((m_integ >>> 4) >= 4096 + 128) && first_nz < 150000) begin
            @(negedge clk);
            first_nz++;
            if ((m_acc >= 32'h3000 && m_acc <= 32'h4800) ||
                (model_inc(m_err, m_integ) == 0 && m_acc > 0 && m_acc < 32'h8000)) begin
                ref_i = 1'b1;
                repeat (3) @(negedge clk);
                ref_i = 1'b0;
                repeat (2) @(negedge clk);
                first_nz += 5;
            end
        end
        chk((m_integ >>> 4) >= 4096 + 128, "R8 integrator reached clamp level",
            int'(m_integ >>> 4), 4224);
        repeat (20) @(negedge clk);
        r0 = rclk_o;
        stable = 1'b1;
        for (int k = 0; k < 40; k++) begin
            @(negedge clk);
            if (rclk_o != r0 || wrap_o) stable = 1'b0;
        end
        chk(stable, "R6 step clamped at zero holds phase", stable, 1);

        summary_and_end();
    end
endmodule